// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a free-running interval timer for a processor subsystem. Software programs a 24-bit start value and sets a run bit. From then on the counter steps down by one on every clock edge where the tick-enable input is high. When the counter steps from one to zero, a sticky wrap flag is raised. If interrupts are enabled, a one-cycle request pulse is also raised. On the next tick after zero, the counter is loaded again from the start value. With a start value of N, a wrap therefore happens every N+1 ticks. A start value of zero keeps the counter parked at zero, and no wrap occurs.

Software talks to the block through a simple synchronous port. A write is applied at the edge where the write strobe is high. A read returns its data on the cycle after the read strobe. Reading the control word also clears the wrap flag, so a polling loop sees each wrap exactly once. A write of any value to the count word forces the count and the flag to zero, so the following tick reloads the counter.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, start value and count are zero, and `irq` and `rd_data` are low.
- R2: The control word sits at offset 0x0. Bit 0 is the run bit and bit 1 is the interrupt enable; both can be written and read back. Bit 16 reads the wrap flag and ignores writes. All other bits read as zero. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: The start value at offset 0x4 keeps only its low 24 bits. The start value and the count at offset 0x8 both read with bits 31..24 as zero.
- R4: At a clock edge where the run bit and `tick_en` are both high, a non-zero count decreases by one. If either of them is low, the count holds.
- R5: At a tick edge where the count is zero, the count loads the start value.
- R6: The tick edge on which the count goes from one to zero sets the wrap flag. The flag stays set until it is cleared.
- R7: A read of the control word clears the wrap flag after that read, and the read returns the old flag. If a set falls on the same edge as such a read, the set wins.
- R8: A write of any value to offset 0x8 makes the count zero and clears the wrap flag. This write takes priority over a tick on the same edge.
- R9: `irq` is high for exactly the one cycle after a one-to-zero edge, and only if the interrupt enable is set. With the enable clear, the flag is still set but no pulse is produced.
- R10: A read of an unmapped offset (for example 0xC) returns zero, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable for this edge |
| addr | input | 4 | Byte offset of the register word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A read issued on one cycle returns its data on the next cycle. The bench drives every access on a falling edge and queues the expected word. It then compares that word at the following falling edge, after the capturing rising edge. Count and flag changes take effect at the rising edge where the tick or write applies, so a read issued afterwards sees the new state. A read issued on that same edge returns the old state, and the same-edge flag case relies on this. `irq` rises one edge after the one-to-zero step. The bench tallies pulses on falling edges and compares the tally after a settling delay.

// File: rtl/tick_timer_pkg.sv
// Package: shared register offsets and control-word bit positions for the
// down-counter timer. Assumes byte offsets that fit the address width.
package tick_timer_pkg;
    localparam int OFF_CTRL = 'h0;
    localparam int OFF_LOAD = 'h4;
    localparam int OFF_CUR  = 'h8;
    localparam int BIT_RUN  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_timer_regs.sv
// Module: register decode, the control and start-value storage, and the
// registered read path. Assumes CNT_W <= DATA_W and BIT_FLAG < DATA_W.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output logic              run,
    output logic              irq_en,
    output logic [CNT_W-1:0]  reload,
    output logic              cur_wr,
    output logic              ctrl_rd,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFF_CUR);

    logic              sel_ctrl, sel_load, sel_cur;
    logic [DATA_W-1:0] rd_mux;

    assign sel_ctrl = (addr == A_CTRL);
    assign sel_load = (addr == A_LOAD);
    assign sel_cur  = (addr == A_CUR);
    assign cur_wr   = wr_en & sel_cur;
    assign ctrl_rd  = rd_en & sel_ctrl;

    // Control bits: written only through the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_en && sel_ctrl) begin
            run    <= wr_data[BIT_RUN];
            irq_en <= wr_data[BIT_IEN];
        end
    end

    // Start value: keeps only the low CNT_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr_en && sel_load) begin
            reload <= wr_data[CNT_W-1:0];
        end
    end

    // Read select: zero-extends the narrow fields; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[BIT_RUN]  = run;
            rd_mux[BIT_IEN]  = irq_en;
            rd_mux[BIT_FLAG] = flag;
        end else if (sel_load) begin
            rd_mux = DATA_W'(reload);
        end else if (sel_cur) begin
            rd_mux = DATA_W'(cnt);
        end
    end

    // Read register: data follows the strobe by one cycle, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/tick_timer_count.sv
// Module: the down-counter with its reload, the sticky wrap flag and the
// interrupt pulse. Assumes cur_wr and ctrl_rd are single-edge strobes.
module tick_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             irq_en,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] reload,
    input  logic             cur_wr,
    input  logic             ctrl_rd,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step, hit;

    assign step = run & tick_en & ~cur_wr;
    assign hit  = step & (cnt == ONE);

    // Counter: a write to the count word wins; otherwise step down or reload.
    always_ff @(posedge clk) begin
        if (!rst_n || cur_wr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == '0) ? reload : cnt - ONE;
        end
    end

    // Wrap flag: a set on the one-to-zero step outranks a clear by a read.
    always_ff @(posedge clk) begin
        if (!rst_n || cur_wr) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (ctrl_rd) begin
            flag <= 1'b0;
        end
    end

    // Interrupt: one cycle after the one-to-zero step, if enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= hit & irq_en;
        end
    end
endmodule

// File: rtl/tick_timer.sv
// Module: top level of the periodic reload down-counter timer. Joins the
// register block to the counter core. Assumes one clock and synchronous reset.
module tick_timer #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             run, irq_en, cur_wr, ctrl_rd, flag;
    logic [CNT_W-1:0] reload, cnt;

    tick_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .cnt(cnt), .flag(flag), .run(run), .irq_en(irq_en),
        .reload(reload), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd), .rd_data(rd_data)
    );

    tick_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .irq_en(irq_en), .tick_en(tick_en),
        .reload(reload), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd), .cnt(cnt),
        .flag(flag), .irq(irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
// Module: property checker for the timer, bound to the top module.
// Assumes it observes the internal count, flag and decode strobes.
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              run,
    input logic              cur_wr,
    input logic              ctrl_rd,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              flag
);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !cur_wr && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick_en) && !cur_wr) |=> $stable(cnt));
    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !cur_wr && cnt == '0) |=> cnt == $past(reload));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl_rd && !cur_wr) |=> flag);
    // R8
    cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cnt == '0 && !flag));
    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && cnt == '0));
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(OFF_LOAD) || addr == ADDR_W'(OFF_CUR)))
        |=> (rd_data >> CNT_W) == '0);
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq), .run(run), .cur_wr(cur_wr), .ctrl_rd(ctrl_rd),
    .cnt(cnt), .reload(reload), .flag(flag)
);

// File: tb/tick_timer_test.sv
// Scoreboard bench: tasks drive accesses and queue expected read words,
// a monitor pops and compares them, and a falling-edge tally counts irq pulses.
module tick_timer_test;
    localparam int CLK_P = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_CTRL = 4'h0;
    localparam logic [AW-1:0] A_LOAD = 4'h4;
    localparam logic [AW-1:0] A_CUR  = 4'h8;
    localparam logic [AW-1:0] A_BAD  = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    bit done = 1'b0;
    logic rd_pend = 1'b0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    // Remember which edges captured a read.
    always @(posedge clk) rd_pend <= rd_en;

    // Monitor: count irq pulses and compare read data against the queue.
    always @(negedge clk) begin
        if (irq) irq_seen++;
        if (rd_pend) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2: read data %h with no expected entry, expected none", rd_data);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic chk_irq(input int e, input string t);
        #1;
        checks++;
        if (irq_seen != e) begin
            failures++;
            $display("FAIL %s: irq pulses=%0d expected %0d", t, irq_seen, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== '0 || irq !== 1'b0) begin
            failures++;
            $display("FAIL R1: rd_data=%h irq=%b expected 0 0", rd_data, irq);
        end
        rst_n = 1'b1;
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_LOAD, 32'h0, "R1 load");
        rd(A_CUR,  32'h0, "R1 count");
        chk_irq(0, "R1 irq");

        wr(A_LOAD, 32'hFFFF_FFFF);
        rd(A_LOAD, 32'h00FF_FFFF, "R3 load width");
        wr(A_BAD, 32'h0000_0003);
        rd(A_BAD,  32'h0, "R10 unmapped read");
        rd(A_CTRL, 32'h0, "R10 unmapped write");
        rd(A_LOAD, 32'h00FF_FFFF, "R10 load kept");

        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h0000_0003, "R2 ctrl bits");
        wr(A_LOAD, 32'd5);
        rd(A_CUR, 32'h0, "R4 no tick holds");

        ticks(1);
        rd(A_CUR, 32'd5, "R5 reload from zero");
        rd(A_CTRL, 32'h0000_0003, "R6 no flag yet");
        ticks(3);
        rd(A_CUR, 32'd2, "R4 decrement");
        ticks(2);
        chk_irq(1, "R9 pulse on wrap");
        rd(A_CUR,  32'd0, "R4 reached zero");
        rd(A_CTRL, 32'h0001_0003, "R6 flag set");
        rd(A_CTRL, 32'h0000_0003, "R7 flag cleared by read");

        wr(A_CTRL, 32'h1);
        ticks(1);
        ticks(5);
        chk_irq(1, "R9 no pulse when disabled");
        rd(A_CTRL, 32'h0001_0001, "R9 flag without irq");

        ticks(1);
        ticks(5);
        ticks(2);
        rd(A_CUR, 32'd4, "R5 periodic reload");
        tick_en = 1'b1;
        wr(A_CUR, 32'h0000_1234);
        tick_en = 1'b0;
        rd(A_CUR,  32'h0, "R8 count cleared");
        rd(A_CTRL, 32'h0000_0001, "R8 flag cleared");

        ticks(1);
        ticks(4);
        tick_en = 1'b1;
        rd(A_CTRL, 32'h0000_0001, "R7 same-edge read returns old flag");
        tick_en = 1'b0;
        rd(A_CTRL, 32'h0001_0001, "R7 same-edge set wins");
        rd(A_CTRL, 32'h0000_0001, "R7 later read clears");

        ticks(2);
        wr(A_CTRL, 32'h0);
        ticks(3);
        rd(A_CUR,  32'd4, "R4 run low holds");
        rd(A_CTRL, 32'h0, "R2 run cleared");

        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h3);
        ticks(10);
        @(negedge clk);
        chk_irq(4, "R9 three wraps");
        rd(A_CUR,  32'h0, "R5 short period count");
        rd(A_CTRL, 32'h0001_0003, "R6 flag after wraps");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run still active at 200000 cycles, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule